// File: doc/BRIEF.md
# Float-to-Integer Truncating Converter

This block turns a binary floating-point operand into a signed two's-complement integer. The fraction is always dropped, so both positive and negative values round toward zero. Each input is sorted into one of five classes: zero, subnormal, normal, infinity or not-a-number. Each class has its own result and flag rules. Finite values too large for the integer saturate to the nearest end of the integer range. Three per-operation flag pulses are produced: invalid-operation, inexact and input-denormal. A status register outside the block may collect them. A flush-to-zero control input selects how subnormal operands are treated.

The operand is presented with a valid strobe. One clock cycle later the registered result appears, together with its flags and a matching valid strobe. The integer is placed in a wider destination word, and the bits above the integer are zero, not copies of the sign bit. The exponent, mantissa, integer and destination widths are all parameters. By default the block takes a 32-bit single-precision operand and returns a 32-bit integer in a 64-bit word.

Top module: `ftoi_trunc`

## Requirements
- R1: A finite normal operand whose truncated value fits the signed integer produces exactly that value, with its fraction discarded toward zero for either sign.
- R2: A not-a-number operand (exponent all ones, mantissa nonzero) of either sign yields 0 with invalid set and inexact and denormal clear.
- R3: An infinite operand (exponent all ones, mantissa zero) yields the largest positive integer (0x7FFFFFFF by default) when the sign bit is 0, and the most negative integer (0x80000000) when it is 1. Invalid is set.
- R4: A finite operand of magnitude 2^(INT_W-1) or more, other than the exact negative value in R5, saturates by sign as in R3. It sets invalid, and inexact stays clear whenever invalid is set.
- R5: An operand equal to exactly -2^(INT_W-1) produces the most negative integer with no flag raised.
- R6: Inexact is set for an in-range normal operand exactly when a nonzero fraction was discarded; otherwise it is clear.
- R7: When the flush-to-zero input is 1, a subnormal operand (exponent zero, mantissa nonzero) yields 0 with only the denormal flag set.
- R8: When the flush-to-zero input is 0, a subnormal operand yields 0 with only the inexact flag set.
- R9: A zero operand of either sign yields 0 with no flag set.
- R10: Destination bits above the integer width are always 0, so a negative result is zero-extended.
- R11: Outputs are registered with one cycle of latency, and out_valid follows in_valid. While out_valid is low all three flags are low. A synchronous active-high reset clears every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_bits | input | EXP_W+MAN_W+1 (32) | Floating-point operand: sign, exponent, mantissa from the top down |
| in_ftz | input | 1 | Flush-to-zero mode for subnormal operands |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | DST_W (64) | Integer result, zero-extended to the destination width |
| out_invalid | output | 1 | Invalid-operation pulse |
| out_inexact | output | 1 | Inexact pulse |
| out_denorm | output | 1 | Input-denormal pulse |

## Verification
The main instance is built in a half-precision shape: EXP_W=5, MAN_W=10, INT_W=16, DST_W=32. At that size every one of the 65,536 operand codes can be fed through in both flush-to-zero modes. Every class is covered, along with every exponent at which the shifter crosses from fraction-dropping to exact to saturating, and the one-code boundary at -2^15. A second instance keeps the default single-precision shape. Directed operands check the 2^31 boundary, values just past it and the upper 32 bits of the 64-bit destination.

// File: rtl/ftoi_pkg.sv
package ftoi_pkg;
  typedef enum logic [2:0] {
    FC_ZERO = 3'd0,
    FC_SUB  = 3'd1,
    FC_NORM = 3'd2,
    FC_INF  = 3'd3,
    FC_NAN  = 3'd4
  } fclass_e;
endpackage

// File: rtl/ftoi_classify.sv
module ftoi_classify
  import ftoi_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W-1:0] man_i,
  output fclass_e          cls_o
);
  logic exp_zero, exp_ones, man_zero;

  assign exp_zero = (exp_i == '0);
  assign exp_ones = &exp_i;
  assign man_zero = (man_i == '0);

  always_comb begin
    if (exp_ones)      cls_o = man_zero ? FC_INF : FC_NAN;
    else if (exp_zero) cls_o = man_zero ? FC_ZERO : FC_SUB;
    else               cls_o = FC_NORM;
  end
endmodule

// File: rtl/ftoi_magnitude.sv
module ftoi_magnitude #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W-1:0] man_i,
  input  logic             sign_i,
  output logic [INT_W-1:0] mag_o,
  output logic             lost_o,
  output logic             big_o
);
  localparam int SIG_W = MAN_W + 1;
  localparam int EXT_W = INT_W + MAN_W;
  localparam int SH_W  = $clog2(INT_W);
  localparam logic [31:0] BIAS_U = 32'((1 << (EXP_W - 1)) - 1);
  localparam logic [31:0] TOP_U  = BIAS_U + 32'(INT_W - 1);

  logic [31:0]    e_ext;
  logic [SIG_W-1:0] sig;
  logic [EXT_W-1:0] ext;
  logic [SH_W-1:0]  shamt;

  assign e_ext = 32'(exp_i);
  assign sig   = {1'b1, man_i};

  always_comb begin
    shamt  = '0;
    ext    = '0;
    mag_o  = '0;
    lost_o = 1'b0;
    big_o  = 1'b0;
    if (e_ext < BIAS_U) begin
      lost_o = 1'b1;
    end else if (e_ext > TOP_U) begin
      big_o = 1'b1;
    end else begin
      shamt  = SH_W'(e_ext - BIAS_U);
      ext    = EXT_W'(sig) << shamt;
      mag_o  = ext[MAN_W +: INT_W];
      lost_o = |ext[MAN_W-1:0];
      big_o  = mag_o[INT_W-1] && !(sign_i && (mag_o[INT_W-2:0] == '0));
    end
  end
endmodule

// File: rtl/ftoi_resolve.sv
module ftoi_resolve
  import ftoi_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  fclass_e          cls_i,
  input  logic             sign_i,
  input  logic             ftz_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             lost_i,
  input  logic             big_i,
  output logic [INT_W-1:0] res_o,
  output logic             inv_o,
  output logic             inx_o,
  output logic             den_o
);
  localparam logic [INT_W-1:0] MAX_V = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] MIN_V = {1'b1, {(INT_W-1){1'b0}}};

  logic [INT_W-1:0] sat_v;
  assign sat_v = sign_i ? MIN_V : MAX_V;

  always_comb begin
    res_o = '0;
    inv_o = 1'b0;
    inx_o = 1'b0;
    den_o = 1'b0;
    unique case (cls_i)
      FC_ZERO: ;
      FC_SUB: begin
        if (ftz_i) den_o = 1'b1;
        else       inx_o = 1'b1;
      end
      FC_NAN:  inv_o = 1'b1;
      FC_INF: begin
        inv_o = 1'b1;
        res_o = sat_v;
      end
      default: begin
        if (big_i) begin
          inv_o = 1'b1;
          res_o = sat_v;
        end else begin
          res_o = sign_i ? (~mag_i + 1'b1) : mag_i;
          inx_o = lost_i;
        end
      end
    endcase
  end
endmodule

// File: rtl/ftoi_trunc.sv
module ftoi_trunc
  import ftoi_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  parameter int DST_W = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [EXP_W+MAN_W:0]   in_bits,
  input  logic                   in_ftz,
  output logic                   out_valid,
  output logic [DST_W-1:0]       out_result,
  output logic                   out_invalid,
  output logic                   out_inexact,
  output logic                   out_denorm
);
  localparam int PAD_W = DST_W - INT_W;

  logic             sign;
  logic [EXP_W-1:0] expf;
  logic [MAN_W-1:0] manf;
  fclass_e          cls;
  logic [INT_W-1:0] mag, res;
  logic             lost, big, inv, inx, den;
  logic [DST_W-1:0] wide;

  assign sign = in_bits[EXP_W+MAN_W];
  assign expf = in_bits[MAN_W +: EXP_W];
  assign manf = in_bits[MAN_W-1:0];

  ftoi_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
    .exp_i(expf), .man_i(manf), .cls_o(cls)
  );

  ftoi_magnitude #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_mag (
    .exp_i(expf), .man_i(manf), .sign_i(sign),
    .mag_o(mag), .lost_o(lost), .big_o(big)
  );

  ftoi_resolve #(.INT_W(INT_W)) u_res (
    .cls_i(cls), .sign_i(sign), .ftz_i(in_ftz), .mag_i(mag),
    .lost_i(lost), .big_i(big), .res_o(res),
    .inv_o(inv), .inx_o(inx), .den_o(den)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign wide = {{PAD_W{1'b0}}, res};
    end else begin : g_nopad
      assign wide = res;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      out_denorm  <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_invalid <= in_valid & inv;
      out_inexact <= in_valid & inx;
      out_denorm  <= in_valid & den;
      if (in_valid) out_result <= wide;
    end
  end
endmodule

// File: rtl/ftoi_trunc_chk.sv
module ftoi_trunc_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  parameter int DST_W = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [EXP_W+MAN_W:0] in_bits,
  input logic                 in_ftz,
  input logic                 out_valid,
  input logic [DST_W-1:0]     out_result,
  input logic                 out_invalid,
  input logic                 out_inexact,
  input logic                 out_denorm
);
  logic e_ones, e_zero, m_zero;
  assign e_ones = &in_bits[MAN_W +: EXP_W];
  assign e_zero = (in_bits[MAN_W +: EXP_W] == '0);
  assign m_zero = (in_bits[MAN_W-1:0] == '0);

  assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(out_invalid || out_inexact || out_denorm));
  assert_inv_no_inexact_R4: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> !out_inexact);
  assert_nan_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && e_ones && !m_zero) |=> (out_invalid && out_result == '0));
  assert_ftz_sub_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && e_zero && !m_zero && in_ftz) |=>
      (out_denorm && !out_invalid && !out_inexact && out_result == '0));
  assert_zero_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && e_zero && m_zero) |=>
      (!out_denorm && !out_invalid && !out_inexact && out_result == '0));

  generate
    if (DST_W > INT_W) begin : g_hi
      assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_result[DST_W-1:INT_W] == '0));
    end
  endgenerate
endmodule

bind ftoi_trunc ftoi_trunc_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .DST_W(DST_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
  .in_ftz(in_ftz), .out_valid(out_valid), .out_result(out_result),
  .out_invalid(out_invalid), .out_inexact(out_inexact),
  .out_denorm(out_denorm)
);

// File: tb/ftoi_trunc_test.sv
module ftoi_trunc_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int tests = 0;
  int failed = 0;

  // small instance: half-precision operand, 16-bit integer, 32-bit dest
  logic        s_valid = 1'b0, s_ftz = 1'b0;
  logic [15:0] s_bits = '0;
  logic        s_ov, s_inv, s_inx, s_den;
  logic [31:0] s_res;

  ftoi_trunc #(.EXP_W(5), .MAN_W(10), .INT_W(16), .DST_W(32)) uut (
    .clk(clk), .rst(rst), .in_valid(s_valid), .in_bits(s_bits),
    .in_ftz(s_ftz), .out_valid(s_ov), .out_result(s_res),
    .out_invalid(s_inv), .out_inexact(s_inx), .out_denorm(s_den)
  );

  // default-shape instance
  logic        w_valid = 1'b0, w_ftz = 1'b0;
  logic [31:0] w_bits = '0;
  logic        w_ov, w_inv, w_inx, w_den;
  logic [63:0] w_res;

  ftoi_trunc uut_wide (
    .clk(clk), .rst(rst), .in_valid(w_valid), .in_bits(w_bits),
    .in_ftz(w_ftz), .out_valid(w_ov), .out_result(w_res),
    .out_invalid(w_inv), .out_inexact(w_inx), .out_denorm(w_den)
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp,
                       logic [3:0] gf, logic [3:0] ef);
    tests++;
    if (got !== exp || gf !== ef) begin
      failed++;
      $display("FAIL %s: result %h flags(v,inv,inx,den) %b, expected %h %b",
               req, got, gf, exp, ef);
    end
  endtask

  // arithmetic reference for the half-precision instance
  task automatic model_small(input logic [15:0] b, input logic ftz,
                             output logic [15:0] r, output logic [2:0] f,
                             output string tag);
    int  e, m, tv;
    real v;
    e = int'(b[14:10]);
    m = int'(b[9:0]);
    r = '0;
    f = 3'b000;
    if (e == 31) begin
      f = 3'b100;
      if (m != 0) tag = "R2";
      else begin
        tag = "R3";
        r = b[15] ? 16'h8000 : 16'h7FFF;
      end
    end else if (e == 0) begin
      if (m == 0) tag = "R9";
      else if (ftz) begin tag = "R7"; f = 3'b001; end
      else begin tag = "R8"; f = 3'b010; end
    end else begin
      v = $itor(1024 + m) * (2.0 ** (e - 25));
      if (b[15]) v = -v;
      tv = $rtoi(v);
      if (tv > 32767 || tv < -32768) begin
        tag = "R4";
        f = 3'b100;
        r = b[15] ? 16'h8000 : 16'h7FFF;
      end else begin
        r = tv[15:0];
        f[1] = ($itor(tv) != v);
        if (tv == -32768) tag = "R5";
        else if (f[1]) tag = "R6";
        else tag = "R1";
      end
    end
  endtask

  task automatic run_wide(input logic [31:0] b, input logic ftz,
                          input logic [31:0] er, input logic [2:0] ef,
                          input string req);
    @(negedge clk);
    w_bits = b; w_ftz = ftz; w_valid = 1'b1;
    @(negedge clk);
    w_valid = 1'b0;
    check(req, w_res, {32'h0, er}, {w_ov, w_inv, w_inx, w_den}, {1'b1, ef});
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    tests++;
    failed++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    logic [15:0] er;
    logic [2:0]  ef;
    string       tag;
    logic        pend;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state and idle outputs
    check("R11", {32'h0, s_res}, 64'h0, {s_ov, s_inv, s_inx, s_den}, 4'b0);
    check("R11", w_res, 64'h0, {w_ov, w_inv, w_inx, w_den}, 4'b0);

    // exhaustive sweep of the small instance, one operand per cycle
    pend = 1'b0;
    er = '0; ef = '0; tag = "";
    for (int fz = 0; fz < 2; fz++) begin
      for (int b = 0; b < 65536; b++) begin
        @(negedge clk);
        if (pend)
          check(tag, {32'h0, s_res}, {48'h0, er},
                {s_ov, s_inv, s_inx, s_den}, {1'b1, ef});
        s_bits  = 16'(b);
        s_ftz   = fz[0];
        s_valid = 1'b1;
        model_small(16'(b), fz[0], er, ef, tag);
        pend = 1'b1;
      end
    end
    @(negedge clk);
    check(tag, {32'h0, s_res}, {48'h0, er},
          {s_ov, s_inv, s_inx, s_den}, {1'b1, ef});
    s_valid = 1'b0;
    @(negedge clk);
    // R11: flags drop with no operand
    check("R11", 64'(s_ov), 64'h0, {1'b0, s_inv, s_inx, s_den}, 4'b0);

    // directed cases on the default shape
    run_wide(32'h4F000000, 1'b0, 32'h7FFFFFFF, 3'b100, "R4");   // 2^31
    run_wide(32'hCF000000, 1'b0, 32'h80000000, 3'b000, "R5");   // -2^31
    run_wide(32'hCF000001, 1'b0, 32'h80000000, 3'b100, "R4");   // below -2^31
    run_wide(32'h4EFFFFFF, 1'b0, 32'h7FFFFF80, 3'b000, "R1");   // largest fit
    run_wide(32'hC0490FDB, 1'b0, 32'hFFFFFFFD, 3'b010, "R6");   // -3.14159
    run_wide(32'hBF800000, 1'b0, 32'hFFFFFFFF, 3'b000, "R10");  // -1.0
    run_wide(32'h4B800000, 1'b0, 32'h01000000, 3'b000, "R1");   // 2^24
    run_wide(32'h3F000000, 1'b0, 32'h00000000, 3'b010, "R6");   // 0.5
    run_wide(32'h7F800000, 1'b0, 32'h7FFFFFFF, 3'b100, "R3");   // +inf
    run_wide(32'hFF800000, 1'b0, 32'h80000000, 3'b100, "R3");   // -inf
    run_wide(32'hFFC00000, 1'b0, 32'h00000000, 3'b100, "R2");   // -NaN
    run_wide(32'h00000001, 1'b1, 32'h00000000, 3'b001, "R7");
    run_wide(32'h807FFFFF, 1'b0, 32'h00000000, 3'b010, "R8");
    run_wide(32'h80000000, 1'b0, 32'h00000000, 3'b000, "R9");   // -0
    @(negedge clk);
    check("R11", 64'(w_ov), 64'h0, {1'b0, w_inv, w_inx, w_den}, 4'b0);

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule